// File: doc/BRIEF.md
# Memory-Counter Disk Transfer Engine

This block moves words between a word-addressed disk store and main memory. It follows a three-step data-break pattern. The word count and the current memory address are not held in registers. They sit in two fixed main-memory words. For every word, the engine reads each of them, increments it and writes it back, and only then moves the data word. One transfer runs in one of three functions: disk to memory, memory to disk, or a compare of memory against disk. The transfer ends when the incremented word count wraps to zero or when an error stops it.

Before each word moves, the engine checks the disk address against the attached capacity. Before each disk write, it checks a per-disk lock mask, with one bit per track group. A compare mismatch also stops the run. At the end the engine raises `done`, with at most one error flag set. In burst mode the words follow each other back-to-back. Otherwise the engine waits a fixed number of idle cycles between words.

The memory port and the disk port are request/grant streams. The engine raises `*_req` (valid) together with the address, the write enable and the write data. It holds all of them stable until the cycle in which `*_gnt` (ready) is high. A grant can be withheld for any number of cycles, which is how the port applies back-pressure. Read data is returned on `*_rdata` in the cycle after the grant. Only one request is outstanding on the two ports together.

Top module: `dbx_xfer`

## Requirements
- R1: For each word, the engine reads memory word 30 (word count), writes back that value plus 1 (18-bit), then reads memory word 31 (current address) and writes back that value plus 1 (18-bit). All four accesses finish before the data word moves. The data memory address `pa` is the low 15 bits of the incremented current address.
- R2: After a word moves, if the incremented word count is 0, the transfer ends with `done`=1 and `busy`=0.
- R3: The read function (`func`=1) reads disk[da] and writes it to memory[pa]. When `pa` >= `MEM_WORDS`, the memory write is skipped, but the counters and the disk address still advance.
- R4: The write function (`func`=2) reads memory[pa] and writes it to disk[da]. The lock bit is `lock_map[da[20:18]*16 + da[17:14]]`. If it is set, the transfer stops with `err_wlk` after the counter updates, and no data access is made.
- R5: The compare function (`func`=3) reads memory[pa] and then disk[da]. On a mismatch it stops with `err_wchk`, and the disk address is not advanced for that word.
- R6: Before the counter accesses of each word, if `{0,da}` >= `capacity`, the transfer stops with `err_nxd` and makes no further access.
- R7: The disk address increments by 1 after each completed word. `da_out` shows the current disk address.
- R8: With `burst`=0, the engine waits `GAP_CYCLES` idle cycles after each word before it starts the next one. With `burst`=1, the next word starts at once.
- R9: While `*_req` is high and `*_gnt` is low, the address, write enable and write data hold steady. `mem_req` and `dsk_req` are never high together.
- R10: A `start` pulse is ignored while `busy`=1, and it is ignored when `func`=0. An accepted start clears `done` and all error flags.
- R11: After reset, `busy`, `done` and the error flags are 0, and no request is raised.
- R12: At most one of `err_nxd`, `err_wlk` and `err_wchk` is set, and `err` is their OR. Every ending sets `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| func | input | 2 | 1 = disk to memory, 2 = memory to disk, 3 = compare, 0 = none |
| burst | input | 1 | 1 = back-to-back words, 0 = insert the word gap |
| da_init | input | 21 | Starting disk address |
| capacity | input | 22 | Attached capacity in words |
| lock_map | input | 128 | Lock bits, indexed disk*16 + track group |
| mem_req | output | 1 | Memory request (valid) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 18 | Memory write data |
| mem_gnt | input | 1 | Memory grant (ready) |
| mem_rdata | input | 18 | Memory read data, valid the cycle after the grant |
| dsk_req | output | 1 | Disk request (valid) |
| dsk_we | output | 1 | Disk write enable |
| dsk_addr | output | 21 | Disk word address |
| dsk_wdata | output | 18 | Disk write data |
| dsk_gnt | input | 1 | Disk grant (ready) |
| dsk_rdata | input | 18 | Disk read data, valid the cycle after the grant |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer ended; held until the next accepted start |
| err | output | 1 | Any error flag is set |
| err_nxd | output | 1 | Address at or beyond capacity |
| err_wlk | output | 1 | Write to a locked track group |
| err_wchk | output | 1 | Compare mismatch |
| da_out | output | 21 | Current disk address |

## Verification
Each request is accepted at the clock edge where request and grant are both high. The responder samples request and grant at the falling edge before that edge, so it compares each accepted transfer against the next entry of the model's expected queue one half-cycle after the acceptance. At that same falling edge it places the read data, which the engine captures at the next rising edge, one cycle after the grant.

End status is not tied to a fixed cycle count, because grants are deliberately stalled. Flags and the disk address are checked three cycles after `done` rises, at which point the queue must be empty. Word spacing is measured between accepted word-count reads and compared with `GAP_CYCLES`.

// File: rtl/dbx_pkg.sv
package dbx_pkg;

  typedef enum logic [1:0] {
    FN_NONE = 2'd0,
    FN_RD   = 2'd1,
    FN_WR   = 2'd2,
    FN_CMP  = 2'd3
  } dbx_fn_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WC_RD,
    ST_WC_WR,
    ST_CA_RD,
    ST_CA_WR,
    ST_MEM_RD,
    ST_DSK_RD,
    ST_MEM_WR,
    ST_DSK_WR,
    ST_ADV,
    ST_GAP
  } dbx_state_e;

endpackage

// File: rtl/dbx_req_port.sv
// Request/grant issuer: latches one access on go, holds it until granted,
// then flags ack in the cycle the returned read data is valid.
module dbx_req_port #(
  parameter int AW = 15,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  input  logic          bus_gnt,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          ack
);

  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      pend_q    <= 1'b0;
    end else begin
      pend_q <= bus_req && bus_gnt;
      if (go) begin
        bus_req   <= 1'b1;
        bus_we    <= go_we;
        bus_addr  <= go_addr;
        bus_wdata <= go_wdata;
      end else if (bus_req && bus_gnt) begin
        bus_req <= 1'b0;
      end
    end
  end

  assign ack = pend_q;

endmodule

// File: rtl/dbx_lock_lookup.sv
// Selects the lock bit of one track group on one disk.
module dbx_lock_lookup #(
  parameter int NDISK = 8,
  parameter int NGRP  = 16,
  localparam int DSEL_W = $clog2(NDISK),
  localparam int GRP_W  = $clog2(NGRP)
) (
  input  logic [NDISK*NGRP-1:0] lock_map,
  input  logic [DSEL_W-1:0]     disk_sel,
  input  logic [GRP_W-1:0]      grp_sel,
  output logic                  locked
);

  logic [NGRP-1:0] row [NDISK];

  for (genvar g = 0; g < NDISK; g++) begin : g_row
    assign row[g] = lock_map[g*NGRP +: NGRP];
  end

  assign locked = row[disk_sel][grp_sel];

endmodule

// File: rtl/dbx_gap_timer.sv
// Counts the idle interval between words; fire is high in its last cycle.
module dbx_gap_timer #(
  parameter int GAP = 16,
  localparam int CW = $clog2(GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic fire
);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (arm) begin
      cnt_q <= CW'(GAP - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign fire = run_q && (cnt_q == '0);

endmodule

// File: rtl/dbx_xfer.sv
module dbx_xfer
  import dbx_pkg::*;
#(
  parameter int WORD_W     = 18,
  parameter int DA_W       = 21,
  parameter int MEM_AW     = 15,
  parameter int MEM_WORDS  = 4096,
  parameter int NDISK      = 8,
  parameter int NGRP       = 16,
  parameter int WC_LOC     = 30,
  parameter int CA_LOC     = 31,
  parameter int GAP_CYCLES = 16,
  localparam int CAP_W  = DA_W + 1,
  localparam int DSEL_W = $clog2(NDISK),
  localparam int GRP_W  = $clog2(NGRP),
  localparam int GRP_LSB = DA_W - DSEL_W - GRP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            func,
  input  logic                  burst,
  input  logic [DA_W-1:0]       da_init,
  input  logic [CAP_W-1:0]      capacity,
  input  logic [NDISK*NGRP-1:0] lock_map,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [MEM_AW-1:0]     mem_addr,
  output logic [WORD_W-1:0]     mem_wdata,
  input  logic                  mem_gnt,
  input  logic [WORD_W-1:0]     mem_rdata,
  output logic                  dsk_req,
  output logic                  dsk_we,
  output logic [DA_W-1:0]       dsk_addr,
  output logic [WORD_W-1:0]     dsk_wdata,
  input  logic                  dsk_gnt,
  input  logic [WORD_W-1:0]     dsk_rdata,
  output logic                  busy,
  output logic                  done,
  output logic                  err,
  output logic                  err_nxd,
  output logic                  err_wlk,
  output logic                  err_wchk,
  output logic [DA_W-1:0]       da_out
);

  dbx_state_e        state_q;
  dbx_fn_e           fn_q;
  logic              burst_q;
  logic              waiting_q;
  logic [DA_W-1:0]   da_q;
  logic [WORD_W-1:0] wc_q;
  logic [WORD_W-1:0] ca_q;
  logic [WORD_W-1:0] mdat_q;
  logic [WORD_W-1:0] ddat_q;
  logic [MEM_AW-1:0] pa;
  logic              pa_installed;

  logic              mem_go, mem_go_we, mem_ack;
  logic [MEM_AW-1:0] mem_go_addr;
  logic [WORD_W-1:0] mem_go_wdata;
  logic              dsk_go, dsk_go_we, dsk_ack;
  logic              locked, gap_arm, gap_fire;

  assign pa           = ca_q[MEM_AW-1:0];
  assign pa_installed = (32'(pa) < MEM_WORDS);

  // Access issue for the current step, once per step.
  always_comb begin
    mem_go       = 1'b0;
    mem_go_we    = 1'b0;
    mem_go_addr  = pa;
    mem_go_wdata = ddat_q;
    dsk_go       = 1'b0;
    dsk_go_we    = 1'b0;
    if (!waiting_q) begin
      unique case (state_q)
        ST_WC_RD:  begin mem_go = 1'b1; mem_go_addr = MEM_AW'(WC_LOC); end
        ST_WC_WR:  begin
          mem_go = 1'b1; mem_go_we = 1'b1;
          mem_go_addr = MEM_AW'(WC_LOC); mem_go_wdata = wc_q;
        end
        ST_CA_RD:  begin mem_go = 1'b1; mem_go_addr = MEM_AW'(CA_LOC); end
        ST_CA_WR:  begin
          mem_go = 1'b1; mem_go_we = 1'b1;
          mem_go_addr = MEM_AW'(CA_LOC); mem_go_wdata = ca_q;
        end
        ST_MEM_RD: mem_go = 1'b1;
        ST_MEM_WR: begin mem_go = 1'b1; mem_go_we = 1'b1; end
        ST_DSK_RD: dsk_go = 1'b1;
        ST_DSK_WR: begin dsk_go = 1'b1; dsk_go_we = 1'b1; end
        default: ;
      endcase
    end
  end

  dbx_req_port #(.AW(MEM_AW), .DW(WORD_W)) u_mport (
    .clk(clk), .rst_n(rst_n), .go(mem_go), .go_we(mem_go_we),
    .go_addr(mem_go_addr), .go_wdata(mem_go_wdata), .bus_gnt(mem_gnt),
    .bus_req(mem_req), .bus_we(mem_we), .bus_addr(mem_addr),
    .bus_wdata(mem_wdata), .ack(mem_ack)
  );

  dbx_req_port #(.AW(DA_W), .DW(WORD_W)) u_dport (
    .clk(clk), .rst_n(rst_n), .go(dsk_go), .go_we(dsk_go_we),
    .go_addr(da_q), .go_wdata(mdat_q), .bus_gnt(dsk_gnt),
    .bus_req(dsk_req), .bus_we(dsk_we), .bus_addr(dsk_addr),
    .bus_wdata(dsk_wdata), .ack(dsk_ack)
  );

  dbx_lock_lookup #(.NDISK(NDISK), .NGRP(NGRP)) u_lock (
    .lock_map(lock_map),
    .disk_sel(da_q[DA_W-1 -: DSEL_W]),
    .grp_sel (da_q[GRP_LSB +: GRP_W]),
    .locked  (locked)
  );

  assign gap_arm = (state_q == ST_ADV) && (wc_q != '0) && !burst_q;

  dbx_gap_timer #(.GAP(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .arm(gap_arm), .fire(gap_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      fn_q      <= FN_NONE;
      burst_q   <= 1'b0;
      waiting_q <= 1'b0;
      da_q      <= '0;
      wc_q      <= '0;
      ca_q      <= '0;
      mdat_q    <= '0;
      ddat_q    <= '0;
      done      <= 1'b0;
      err_nxd   <= 1'b0;
      err_wlk   <= 1'b0;
      err_wchk  <= 1'b0;
    end else begin
      if (mem_go || dsk_go)        waiting_q <= 1'b1;
      else if (mem_ack || dsk_ack) waiting_q <= 1'b0;

      unique case (state_q)
        ST_IDLE: if (start && (func != 2'd0)) begin
          da_q     <= da_init;
          fn_q     <= dbx_fn_e'(func);
          burst_q  <= burst;
          done     <= 1'b0;
          err_nxd  <= 1'b0;
          err_wlk  <= 1'b0;
          err_wchk <= 1'b0;
          state_q  <= ST_CHECK;
        end
        ST_CHECK: if ({1'b0, da_q} >= capacity) begin
          err_nxd <= 1'b1;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end else begin
          state_q <= ST_WC_RD;
        end
        ST_WC_RD: if (mem_ack) begin
          wc_q    <= mem_rdata + 1'b1;
          state_q <= ST_WC_WR;
        end
        ST_WC_WR: if (mem_ack) state_q <= ST_CA_RD;
        ST_CA_RD: if (mem_ack) begin
          ca_q    <= mem_rdata + 1'b1;
          state_q <= ST_CA_WR;
        end
        ST_CA_WR: if (mem_ack) begin
          unique case (fn_q)
            FN_RD:   state_q <= ST_DSK_RD;
            FN_WR:   if (locked) begin
              err_wlk <= 1'b1;
              done    <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_MEM_RD;
            end
            default: state_q <= ST_MEM_RD;
          endcase
        end
        ST_MEM_RD: if (mem_ack) begin
          mdat_q  <= mem_rdata;
          state_q <= (fn_q == FN_WR) ? ST_DSK_WR : ST_DSK_RD;
        end
        ST_DSK_RD: if (dsk_ack) begin
          if (fn_q == FN_RD) begin
            ddat_q  <= dsk_rdata;
            state_q <= pa_installed ? ST_MEM_WR : ST_ADV;
          end else if (dsk_rdata != mdat_q) begin
            err_wchk <= 1'b1;
            done     <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            state_q <= ST_ADV;
          end
        end
        ST_MEM_WR: if (mem_ack) state_q <= ST_ADV;
        ST_DSK_WR: if (dsk_ack) state_q <= ST_ADV;
        ST_ADV: begin
          da_q <= da_q + 1'b1;
          if (wc_q == '0) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= burst_q ? ST_CHECK : ST_GAP;
          end
        end
        ST_GAP: if (gap_fire) state_q <= ST_CHECK;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign err    = err_nxd | err_wlk | err_wchk;
  assign da_out = da_q;

endmodule

// File: rtl/dbx_xfer_chk.sv
module dbx_xfer_chk #(
  parameter int DA_W   = 21,
  parameter int MEM_AW = 15,
  parameter int WORD_W = 18,
  parameter int NDISK  = 8,
  parameter int NGRP   = 16,
  localparam int IDX_W = $clog2(NDISK) + $clog2(NGRP)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [DA_W:0]         capacity,
  input logic [NDISK*NGRP-1:0] lock_map,
  input logic                  mem_req,
  input logic                  mem_we,
  input logic [MEM_AW-1:0]     mem_addr,
  input logic [WORD_W-1:0]     mem_wdata,
  input logic                  mem_gnt,
  input logic                  dsk_req,
  input logic                  dsk_we,
  input logic [DA_W-1:0]       dsk_addr,
  input logic [WORD_W-1:0]     dsk_wdata,
  input logic                  dsk_gnt,
  input logic                  busy,
  input logic                  done,
  input logic                  err_nxd,
  input logic                  err_wlk,
  input logic                  err_wchk
);

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_dsk_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_req && !dsk_gnt |=> dsk_req && $stable(dsk_addr) && $stable(dsk_we) && $stable(dsk_wdata));

  assert_one_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && dsk_req));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !dsk_req);

  assert_in_capacity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_req |-> ({1'b0, dsk_addr} < capacity));

  assert_no_locked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_req && dsk_we |-> !lock_map[dsk_addr[DA_W-1 -: IDX_W]]);

  assert_single_error_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_nxd, err_wlk, err_wchk}));

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

endmodule

bind dbx_xfer dbx_xfer_chk #(
  .DA_W(DA_W), .MEM_AW(MEM_AW), .WORD_W(WORD_W), .NDISK(NDISK), .NGRP(NGRP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .capacity(capacity), .lock_map(lock_map),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_gnt(mem_gnt), .dsk_req(dsk_req), .dsk_we(dsk_we), .dsk_addr(dsk_addr),
  .dsk_wdata(dsk_wdata), .dsk_gnt(dsk_gnt), .busy(busy), .done(done),
  .err_nxd(err_nxd), .err_wlk(err_wlk), .err_wchk(err_wchk)
);

// File: tb/sim_dbx_xfer.sv
module sim_dbx_xfer;

  localparam int CLK_P = 10;
  localparam int GAP   = 40;
  localparam int MEMW  = 4096;
  localparam int MASK  = 18'h3FFFF;

  typedef struct {
    bit          dsk;
    bit          we;
    int          addr;
    logic [17:0] d;
  } txn_t;

  logic         clk = 0, rst_n = 0, start = 0, burst = 0;
  logic [1:0]   func = 0;
  logic [20:0]  da_init = 0;
  logic [21:0]  capacity = 22'h100000;
  logic [127:0] lock_map = 128'd0;
  logic         mem_req, mem_we, mem_gnt = 0;
  logic [14:0]  mem_addr;
  logic [17:0]  mem_wdata, mem_rdata = 0;
  logic         dsk_req, dsk_we, dsk_gnt = 0;
  logic [20:0]  dsk_addr;
  logic [17:0]  dsk_wdata, dsk_rdata = 0;
  logic         busy, done, err, err_nxd, err_wlk, err_wchk;
  logic [20:0]  da_out;

  dbx_xfer #(.GAP_CYCLES(GAP), .MEM_WORDS(MEMW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .func(func), .burst(burst),
    .da_init(da_init), .capacity(capacity), .lock_map(lock_map),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .dsk_req(dsk_req), .dsk_we(dsk_we), .dsk_addr(dsk_addr), .dsk_wdata(dsk_wdata),
    .dsk_gnt(dsk_gnt), .dsk_rdata(dsk_rdata),
    .busy(busy), .done(done), .err(err), .err_nxd(err_nxd), .err_wlk(err_wlk),
    .err_wchk(err_wchk), .da_out(da_out)
  );

  always #(CLK_P/2) clk = ~clk;

  int vectors = 0, miscompares = 0, cyc = 0;
  logic [17:0] bmem [int];
  logic [17:0] bdsk [int];
  logic [17:0] mmem [int];
  logic [17:0] mdsk [int];
  txn_t expq [$];
  int   wc_times [$];
  bit   x_nxd, x_wlk, x_wchk;
  int   x_da;

  function automatic logic [17:0] dflt(int a, int salt);
    return 18'((a * 37 + salt * 11 + 5) & MASK);
  endfunction

  function automatic logic [17:0] bm(int a);
    return bmem.exists(a) ? bmem[a] : dflt(a, 1);
  endfunction
  function automatic logic [17:0] bd(int a);
    return bdsk.exists(a) ? bdsk[a] : dflt(a, 2);
  endfunction
  function automatic logic [17:0] mm(int a);
    return mmem.exists(a) ? mmem[a] : dflt(a, 1);
  endfunction
  function automatic logic [17:0] md(int a);
    return mdsk.exists(a) ? mdsk[a] : dflt(a, 2);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void push(bit dsk, bit we, int addr, logic [17:0] d);
    txn_t t;
    t.dsk = dsk; t.we = we; t.addr = addr; t.d = d;
    expq.push_back(t);
  endfunction

  // Behavioural reference: expected bus sequence and ending status.
  function automatic void model(int fn, int da);
    int wc, ca, pa, idx;
    mmem = bmem; mdsk = bdsk;
    x_nxd = 0; x_wlk = 0; x_wchk = 0;
    forever begin
      if (da >= int'(capacity)) begin x_nxd = 1; break; end
      wc = (int'(mm(30)) + 1) & MASK;
      push(0, 0, 30, 0); push(0, 1, 30, 18'(wc)); mmem[30] = 18'(wc);
      ca = (int'(mm(31)) + 1) & MASK;
      push(0, 0, 31, 0); push(0, 1, 31, 18'(ca)); mmem[31] = 18'(ca);
      pa = ca & 32'h7FFF;
      if (fn == 1) begin
        push(1, 0, da, 0);
        if (pa < MEMW) begin push(0, 1, pa, md(da)); mmem[pa] = md(da); end
      end else if (fn == 2) begin
        idx = ((da >> 18) & 7) * 16 + ((da >> 14) & 15);
        if (lock_map[idx]) begin x_wlk = 1; break; end
        push(0, 0, pa, 0); push(1, 1, da, mm(pa)); mdsk[da] = mm(pa);
      end else begin
        push(0, 0, pa, 0); push(1, 0, da, 0);
        if (mm(pa) != md(da)) begin x_wchk = 1; break; end
      end
      da++;
      if (wc == 0) break;
    end
    x_da = da;
  endfunction

  // Bus responder with deterministic grant stalls.
  bit m_acc = 0, d_acc = 0;
  txn_t m_t, d_t;

  task automatic take(txn_t t);
    txn_t e;
    if (t.dsk == 0 && t.we == 0 && t.addr == 30) wc_times.push_back(cyc);
    if (expq.size() == 0) begin
      check(0, "R9", "unexpected bus transfer at address", t.addr, 0);
      return;
    end
    e = expq.pop_front();
    check(e.dsk == t.dsk && e.we == t.we && e.addr == t.addr,
          "R1,R3,R4,R5", "transfer port/dir/address", {t.dsk, t.we, 32'(t.addr)},
          {e.dsk, e.we, 32'(e.addr)});
    if (t.we) check(e.d == t.d, "R1,R3,R4", "write data", t.d, e.d);
  endtask

  initial forever begin
    @(negedge clk);
    cyc++;
    if (m_acc) begin
      take(m_t);
      if (m_t.we) bmem[m_t.addr] = m_t.d; else mem_rdata = bm(m_t.addr);
    end
    if (d_acc) begin
      take(d_t);
      if (d_t.we) bdsk[d_t.addr] = d_t.d; else dsk_rdata = bd(d_t.addr);
    end
    mem_gnt = mem_req && (cyc % 3 != 1);
    dsk_gnt = dsk_req && (cyc % 4 != 0);
    m_acc = mem_gnt;
    d_acc = dsk_gnt;
    m_t.dsk = 0; m_t.we = mem_we; m_t.addr = int'(mem_addr); m_t.d = mem_wdata;
    d_t.dsk = 1; d_t.we = dsk_we; d_t.addr = int'(dsk_addr); d_t.d = dsk_wdata;
  end

  task automatic run(int fn, int da, bit bst, bit restart);
    int n;
    model(fn, da);
    wc_times.delete();
    @(negedge clk);
    start = 1; func = 2'(fn); burst = bst; da_init = 21'(da);
    @(negedge clk);
    start = 0;
    if (restart) begin
      repeat (10) @(negedge clk);
      start = 1; func = 2'd2; da_init = 21'd0;   // R10: ignored while busy
      @(negedge clk);
      start = 0;
    end
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check(n < 20000, "R2", "watchdog waiting for done", n, 0);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R2", "transfers left outstanding", expq.size(), 0);
    check(!busy && done, "R2", "busy/done at end", {busy, done}, 2'b01);
    check({err_nxd, err_wlk, err_wchk} == {x_nxd, x_wlk, x_wchk}, "R12",
          "error flags nxd/wlk/wchk", {err_nxd, err_wlk, err_wchk}, {x_nxd, x_wlk, x_wchk});
    check(err == (x_nxd | x_wlk | x_wchk), "R12", "err summary", err, x_nxd | x_wlk | x_wchk);
    check(int'(da_out) == x_da, "R7", "final disk address", da_out, x_da);
  endtask

  function automatic int min_gap();
    int m = 1 << 30;
    for (int i = 1; i < wc_times.size(); i++)
      if (wc_times[i] - wc_times[i-1] < m) m = wc_times[i] - wc_times[i-1];
    return m;
  endfunction

  function automatic int max_gap();
    int m = 0;
    for (int i = 1; i < wc_times.size(); i++)
      if (wc_times[i] - wc_times[i-1] > m) m = wc_times[i] - wc_times[i-1];
    return m;
  endfunction

  initial begin
    #(CLK_P * 150000);
    check(0, "R2", "global watchdog expired", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int burst_max;
    lock_map[1*16 + 3] = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!busy && !done && !err && !mem_req && !dsk_req, "R11", "reset outputs",
          {busy, done, err, mem_req, dsk_req}, 0);
    rst_n = 1;
    @(negedge clk);

    // Read, burst, 4 words
    bmem[30] = 18'(-4 & MASK); bmem[31] = 18'h000FF;
    run(1, 100, 1, 0);
    burst_max = max_gap();
    check(bm(30) == 0, "R2", "word count wrapped to zero", bm(30), 0);
    check(bm(31) == 18'h103, "R1", "current address after 4 words", bm(31), 18'h103);
    check(bm(18'h100) == bd(100), "R3", "first word stored", bm(18'h100), bd(100));

    // Read, gapped, 4 words, with an ignored start mid-run
    bmem[30] = 18'(-4 & MASK); bmem[31] = 18'h001FF;
    run(1, 200, 0, 1);
    check(min_gap() >= GAP, "R8", "gapped word spacing", min_gap(), GAP);
    check(burst_max < GAP, "R8", "burst word spacing below gap", burst_max, GAP);
    check(wc_times.size() == 4, "R10", "words in run with ignored start", wc_times.size(), 4);

    // Write, burst, 3 words
    bmem[30] = 18'(-3 & MASK); bmem[31] = 18'h002FF;
    run(2, 'h500, 1, 0);
    check(bd('h502) == bm('h302), "R4", "third word written to disk", bd('h502), bm('h302));

    // Write into a locked group: disk 1, group 3
    bmem[30] = 18'(-2 & MASK); bmem[31] = 18'h003FF;
    run(2, (1 << 18) | (3 << 14) | 5, 1, 0);
    check(bm(30) == 18'(-1 & MASK), "R4", "counters advanced once before lock stop",
          bm(30), 18'(-1 & MASK));

    // Compare, matching
    bmem[30] = 18'(-3 & MASK); bmem[31] = 18'h002FF;
    run(3, 'h500, 1, 0);
    check(!err_wchk, "R5", "matching compare clean", err_wchk, 0);

    // Compare, mismatch on second word
    bdsk['h501] = bdsk['h501] ^ 18'h1;
    bmem[30] = 18'(-3 & MASK); bmem[31] = 18'h002FF;
    run(3, 'h500, 0, 0);
    check(err_wchk && da_out == 21'h501, "R5", "mismatch stop address", da_out, 21'h501);

    // Capacity reached mid-run
    bmem[30] = 18'(-4 & MASK); bmem[31] = 18'h00600;
    run(1, 'hFFFFE, 1, 0);
    check(err_nxd, "R6", "capacity error mid-run", err_nxd, 1);

    // Start already beyond capacity: no access at all
    bmem[30] = 18'(-2 & MASK);
    run(2, 'h100000, 1, 0);
    check(bm(30) == 18'(-2 & MASK), "R6", "no counter access beyond capacity",
          bm(30), 18'(-2 & MASK));

    // Read into uninstalled memory: store skipped, counters advance
    bmem[30] = 18'(-3 & MASK); bmem[31] = 18'(MEMW - 2);
    run(1, 300, 1, 0);
    check(!bmem.exists(MEMW), "R3", "no store above installed memory", bmem.exists(MEMW), 0);
    check(bm(31) == 18'(MEMW + 1), "R3", "address advanced past installed memory",
          bm(31), MEMW + 1);

    // Current address wraps at 18 bits
    bmem[30] = 18'(-2 & MASK); bmem[31] = 18'h3FFFF;
    run(1, 400, 1, 0);
    check(bm(31) == 18'h1, "R1", "current address wrap", bm(31), 1);

    // func 0 start is ignored; flags and done unchanged
    @(negedge clk);
    start = 1; func = 2'd0; da_init = 21'd7;
    @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    check(!busy && done && da_out == 21'd402, "R10", "func 0 start ignored",
          {busy, done, da_out}, {1'b0, 1'b1, 21'd402});

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule